// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Flag Arbitration

This block turns an asynchronous serial line into bytes for a processor. It watches the line on a 16x oversampling tick and confirms a start bit at its centre. It then samples eight data bits, an optional parity bit and a stop bit, each at its bit centre, into a shift register. When the stop bit has been sampled, a fixed rule set decides two things: which status flags are raised, and whether the shifted byte is copied into the holding data register.

The processor sees the holding register and four sticky flags: data-full, overrun, framing error and parity error. Each flag is cleared by its own one-cycle clear strobe. The rules matter most when several errors hit the same frame. An overrun protects the unread byte and drops the new one. A framing or parity error still delivers the byte but does not mark it as fresh. While any error flag is pending, no further byte is delivered.

Top module: `async_rx_core`

## Requirements
- R1: After reset, `rxData` is 0 and all four flags are 0.
- R2: A frame with a high stop bit and correct parity, received while all four flags are 0, puts the byte into `rxData` and sets `fullFlag`. The first data bit after the start bit lands in bit 0.
- R3: A frame that completes while `fullFlag` is 1 sets `overrunFlag`, leaves `rxData` unchanged and keeps `fullFlag` at 1.
- R4: A frame whose stop bit is sampled low sets `frameErrFlag`. If no flag was set beforehand, the byte is written to `rxData` and `fullFlag` stays 0.
- R5: When `parityEn` is 1, a parity bit follows the data. The frame is correct when the XOR of the eight data bits and the parity bit equals `parityOdd`. Otherwise `parityErrFlag` is set. If no flag was set beforehand, the byte is written to `rxData` and `fullFlag` stays 0. When `parityEn` is 0, no parity bit is sent and no parity error is possible.
- R6: A frame with several faults sets every flag that applies. Framing plus parity still transfers the byte without setting `fullFlag`. Any combination that includes overrun transfers nothing.
- R7: While any of `overrunFlag`, `frameErrFlag` or `parityErrFlag` is 1, later frames are still received and may raise flags, but `rxData` does not change and `fullFlag` is not set.
- R8: A low pulse on `rxLine` that is high again at the start-bit centre (8 ticks after the detected fall) is ignored: no flag and no data change.
- R9: Each flag falls only in the cycle after its own clear strobe. When a set condition and that flag's clear strobe occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial input line, idles high |
| sampleTick | input | 1 | One-cycle pulse at 16x the bit rate |
| parityEn | input | 1 | 1: a parity bit follows the data bits |
| parityOdd | input | 1 | 1: odd parity, 0: even parity |
| clrFull | input | 1 | Clears `fullFlag` |
| clrOverrun | input | 1 | Clears `overrunFlag` |
| clrFrameErr | input | 1 | Clears `frameErrFlag` |
| clrParityErr | input | 1 | Clears `parityErrFlag` |
| rxData | output | 8 | Holding data register |
| fullFlag | output | 1 | Unread byte present |
| overrunFlag | output | 1 | A byte arrived while full and was dropped |
| frameErrFlag | output | 1 | A stop bit was sampled low |
| parityErrFlag | output | 1 | A parity mismatch was seen |

## Verification
The bench sends random bytes in both parity modes and injects bad stop bits and bad parity bits. It issues random clear masks between frames, so frames land while the register is full and while error flags are still pending. A design that let an overrun overwrite the held byte would show a changed `rxData`. One that set data-full on a damaged frame, or kept delivering bytes under a pending error, would show a wrong flag or a wrong byte after the next frame. Directed cases cover each single fault and each combined fault, plus a short start glitch. A receiver that skipped the mid-start check would shift in a phantom frame after the glitch.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rxState_e;

  typedef struct packed {
    logic shiftBit;
    logic takeParity;
    logic commit;
  } rxCtrl_t;
endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleTick,
  input  logic    rxSync,
  input  logic    parityEn,
  output rxCtrl_t ctrl
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] TOP  = IDX_W'(DATA_W - 1);

  rxState_e state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic atCentre;

  assign atCentre = sampleTick && (tickCnt == LAST);

  always_comb begin
    ctrl = '0;
    ctrl.shiftBit   = atCentre && (state == RX_DATA);
    ctrl.takeParity = atCentre && (state == RX_PARITY);
    ctrl.commit     = atCentre && (state == RX_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (sampleTick) begin
      case (state)
        RX_IDLE: begin
          tickCnt <= '0;
          if (!rxSync) state <= RX_START;
        end
        RX_START: begin
          if (tickCnt == MID) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxSync ? RX_IDLE : RX_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == LAST) begin
            if (bitIdx == TOP) state <= parityEn ? RX_PARITY : RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end
        end
        RX_PARITY: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == LAST) state <= RX_STOP;
        end
        RX_STOP: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == LAST) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_rx_dp.sv
module async_rx_dp
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  rxCtrl_t           ctrl,
  input  logic              clrFull,
  input  logic              clrOverrun,
  input  logic              clrFrameErr,
  input  logic              clrParityErr,
  output logic              rxSync,
  output logic [DATA_W-1:0] rxData,
  output logic              fullFlag,
  output logic              overrunFlag,
  output logic              frameErrFlag,
  output logic              parityErrFlag
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic [DATA_W-1:0] shiftReg;
  logic parBit;
  logic stopBad, parBad, errPending, doXfer, setFull, setOvr;

  assign rxSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], rxLine};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (ctrl.shiftBit)   shiftReg <= {rxSync, shiftReg[DATA_W-1:1]};
      if (ctrl.takeParity) parBit   <= rxSync;
    end
  end

  always_comb begin
    stopBad    = ctrl.commit && !rxSync;
    parBad     = ctrl.commit && parityEn && ((^shiftReg ^ parBit) != parityOdd);
    errPending = overrunFlag || frameErrFlag || parityErrFlag;
    setOvr     = ctrl.commit && fullFlag;
    doXfer     = ctrl.commit && !fullFlag && !errPending;
    setFull    = doXfer && !stopBad && !parBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData        <= '0;
      fullFlag      <= 1'b0;
      overrunFlag   <= 1'b0;
      frameErrFlag  <= 1'b0;
      parityErrFlag <= 1'b0;
    end else begin
      if (doXfer) rxData <= shiftReg;
      fullFlag      <= setFull || (fullFlag      && !clrFull);
      overrunFlag   <= setOvr  || (overrunFlag   && !clrOverrun);
      frameErrFlag  <= stopBad || (frameErrFlag  && !clrFrameErr);
      parityErrFlag <= parBad  || (parityErrFlag && !clrParityErr);
    end
  end
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              sampleTick,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              clrFull,
  input  logic              clrOverrun,
  input  logic              clrFrameErr,
  input  logic              clrParityErr,
  output logic [DATA_W-1:0] rxData,
  output logic              fullFlag,
  output logic              overrunFlag,
  output logic              frameErrFlag,
  output logic              parityErrFlag
);
  rxCtrl_t ctrl;
  logic rxSync;

  async_rx_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxSync(rxSync),
    .parityEn(parityEn), .ctrl(ctrl)
  );

  async_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .parityEn(parityEn),
    .parityOdd(parityOdd), .ctrl(ctrl), .clrFull(clrFull),
    .clrOverrun(clrOverrun), .clrFrameErr(clrFrameErr),
    .clrParityErr(clrParityErr), .rxSync(rxSync), .rxData(rxData),
    .fullFlag(fullFlag), .overrunFlag(overrunFlag),
    .frameErrFlag(frameErrFlag), .parityErrFlag(parityErrFlag)
  );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              commit,
  input logic              rxSync,
  input logic              clrFull,
  input logic              clrOverrun,
  input logic [DATA_W-1:0] rxData,
  input logic              fullFlag,
  input logic              overrunFlag,
  input logic              frameErrFlag,
  input logic              parityErrFlag
);
  // R3
  overrun_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit && fullFlag |=> overrunFlag && fullFlag && $stable(rxData));

  // R7
  pending_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit && (overrunFlag || frameErrFlag || parityErrFlag)
      |=> $stable(rxData) && ($rose(fullFlag) == 1'b0));

  // R4
  stop_low_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    commit && !rxSync |=> frameErrFlag);

  // R9
  full_own_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fullFlag) |-> $past(clrFull));

  // R9
  ovr_own_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrunFlag) |-> $past(clrOverrun));

  // R6
  no_full_on_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> !frameErrFlag && !parityErrFlag && !overrunFlag);
endmodule

bind async_rx_core async_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .commit(ctrl.commit), .rxSync(rxSync),
  .clrFull(clrFull), .clrOverrun(clrOverrun), .rxData(rxData),
  .fullFlag(fullFlag), .overrunFlag(overrunFlag),
  .frameErrFlag(frameErrFlag), .parityErrFlag(parityErrFlag)
);

// File: tb/sim_async_rx_core.sv
module sim_async_rx_core;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int OVS        = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic sampleTick = 1'b0;
  logic parityEn = 1'b0, parityOdd = 1'b0;
  logic clrFull = 1'b0, clrOverrun = 1'b0, clrFrameErr = 1'b0, clrParityErr = 1'b0;
  logic [7:0] rxData;
  logic fullFlag, overrunFlag, frameErrFlag, parityErrFlag;

  int checks = 0, fails = 0;
  bit finished = 0;
  int divCnt = 0;

  logic [7:0] mData;
  logic mFull, mOvr, mFer, mPer;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    divCnt     <= (divCnt == TICK_DIV-1) ? 0 : divCnt + 1;
    sampleTick <= (divCnt == 0);
  end

  async_rx_core u0 (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .parityEn(parityEn), .parityOdd(parityOdd), .clrFull(clrFull),
    .clrOverrun(clrOverrun), .clrFrameErr(clrFrameErr),
    .clrParityErr(clrParityErr), .rxData(rxData), .fullFlag(fullFlag),
    .overrunFlag(overrunFlag), .frameErrFlag(frameErrFlag),
    .parityErrFlag(parityErrFlag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, "rxData", rxData, mData);
    chk(req, "full", fullFlag, mFull);
    chk(req, "overrun", overrunFlag, mOvr);
    chk(req, "frameErr", frameErrFlag, mFer);
    chk(req, "parityErr", parityErrFlag, mPer);
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!sampleTick) @(negedge clk);
    end
  endtask

  function automatic logic goodParity(input logic [7:0] b, input logic odd);
    return (^b) ^ odd;
  endfunction

  // reference rule set applied at the end of a frame
  task automatic modelFrame(input logic [7:0] b, input bit badStop, input bit badPar);
    bit pend, xfer;
    pend = mOvr || mFer || mPer;
    xfer = !mFull && !pend;
    if (mFull) mOvr = 1;
    if (badStop) mFer = 1;
    if (badPar) mPer = 1;
    if (xfer) mData = b;
    if (xfer && !badStop && !badPar) mFull = 1;
  endtask

  task automatic sendFrame(input logic [7:0] b, input bit badStop, input bit badPar);
    logic p;
    p = goodParity(b, parityOdd) ^ badPar;
    rxLine = 1'b0; waitTicks(OVS);
    for (int i = 0; i < 8; i++) begin rxLine = b[i]; waitTicks(OVS); end
    if (parityEn) begin rxLine = p; waitTicks(OVS); end
    rxLine = !badStop; waitTicks(OVS);
    rxLine = 1'b1; waitTicks(OVS + 4);
    modelFrame(b, badStop, badPar && parityEn);
  endtask

  task automatic clearMask(input logic [3:0] m);
    @(negedge clk);
    {clrParityErr, clrFrameErr, clrOverrun, clrFull} = m;
    @(negedge clk);
    {clrParityErr, clrFrameErr, clrOverrun, clrFull} = '0;
    if (m[0]) mFull = 0;
    if (m[1]) mOvr = 0;
    if (m[2]) mFer = 0;
    if (m[3]) mPer = 0;
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'd24681));
    mData = 0; mFull = 0; mOvr = 0; mFer = 0; mPer = 0;
    repeat (5) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    waitTicks(OVS * 2);
    checkAll("R1");

    // R2 clean frame, no parity, bit 0 first
    sendFrame(8'hA5, 0, 0); checkAll("R2");
    // R3 overrun keeps old byte
    sendFrame(8'h3C, 0, 0); checkAll("R3");
    // R9 each strobe clears only its flag
    clearMask(4'b0010); checkAll("R9");
    clearMask(4'b0001); checkAll("R9");
    // R4 framing error alone
    sendFrame(8'h5E, 1, 0); checkAll("R4");
    // R7 pending error blocks a clean frame
    sendFrame(8'h81, 0, 0); checkAll("R7");
    clearMask(4'b0100); checkAll("R9");
    // R5 parity error, even then odd
    parityEn = 1; parityOdd = 0;
    sendFrame(8'h17, 0, 1); checkAll("R5");
    clearMask(4'b1000);
    parityOdd = 1;
    sendFrame(8'hC3, 0, 0); checkAll("R5");
    clearMask(4'b0001);
    sendFrame(8'h66, 0, 1); checkAll("R5");
    clearMask(4'b1000);
    // R6 framing plus parity transfers, no full
    sendFrame(8'h99, 1, 1); checkAll("R6");
    clearMask(4'b1100);
    // R6 overrun plus framing plus parity
    sendFrame(8'h42, 0, 0); checkAll("R2");
    sendFrame(8'hBD, 1, 1); checkAll("R6");
    clearMask(4'b1111); checkAll("R9");
    // R8 short start glitch
    rxLine = 1'b0; waitTicks(3);
    rxLine = 1'b1; waitTicks(OVS * 2);
    checkAll("R8");

    for (int n = 0; n < 150; n++) begin
      logic [7:0] b;
      bit bs, bp;
      b = 8'($urandom);
      parityEn = 1'($urandom);
      parityOdd = 1'($urandom);
      bs = ($urandom % 6) == 0;
      bp = ($urandom % 5) == 0;
      sendFrame(b, bs, bp);
      checkAll(mOvr ? "R3" : (mFer || mPer) ? "R6" : "R2");
      if (($urandom % 3) != 0) begin
        clearMask(4'($urandom));
        checkAll("R9");
      end
    end
    finish();
  end
endmodule